// File: doc/BRIEF.md
# Display Pixel Serializer

The serializer turns a stream of 32-bit display-memory words into single pixels, one per accepted output transfer. The pixel width is picked at run time from 1, 2, 4, 8, 16 or 24 bits. A select input sets which end of the memory word the first pixel comes from. For 24-bit colour, a second select chooses between two layouts. In the unpacked layout each word holds one pixel. In the packed layout four pixels fill three words, so some pixels straddle a word boundary.

Words come from a first-word-fall-through FIFO. While `fifo_empty` is low, `fifo_data` shows the head word, and a one-cycle `fifo_rd` pulse pops it. Pixels leave on a valid/ready port. A pixel transfers on any clock edge where `pix_valid` and `pix_ready` are both high. While `pix_ready` is low, the offered pixel stays in place and nothing is popped, so the FIFO sees back-pressure only through the missing read strobe.

The configuration inputs may change only while the block is idle, with the FIFO empty and no pixel offered. A one-cycle `clear` is pulsed at the start of a new stream. It returns the word position, the packed phase and the held bytes to their start state.

Top module: `lcd_pix_serializer`

## Requirements
- R1: `cfg_size` codes 0, 1, 2, 3, 4 and 5 select pixel widths of 1, 2, 4, 8, 16 and 24 bits. Codes 6 and 7 behave like code 5.
- R2: With `cfg_big_endian`=0 and width w below 24, pixel k of a word (k counted from 0) is word bits [k*w +: w].
- R3: With `cfg_big_endian`=1 and width w below 24, pixel k of a word is word bits [31-k*w -: w]. Bit and byte order inside a pixel are kept as stored.
- R4: A pixel narrower than 24 bits appears in the low bits of `pix_data`, and all bits above it are 0.
- R5: A word yields 32/w pixels for w below 24. `fifo_rd` pulses exactly once per word, in the cycle its last pixel transfers, and never while `fifo_empty` is high.
- R6: In 24-bit unpacked mode (`cfg_packed`=0), each word yields one pixel equal to bits 23:0. Bits 31:24 are dropped, and `cfg_big_endian` has no effect.
- R7: In 24-bit packed little-endian mode, the consecutive words A, B, C yield four pixels in this order: A[23:0], {B[15:0],A[31:24]}, {C[7:0],B[31:16]}, C[31:8].
- R8: In 24-bit packed big-endian mode, the words A, B, C yield four pixels in this order: A[31:8], {A[7:0],B[31:16]}, {B[15:0],C[31:24]}, C[23:0].
- R9: While `pix_valid`=1 and `pix_ready`=0, the next cycle still has `pix_valid`=1 with `pix_data` unchanged, and `fifo_rd` stays 0.
- R10: `pix_valid` equals not `fifo_empty`, except for the fourth pixel of a packed group. That pixel is built only from held bytes and is offered even while the FIFO is empty.
- R11: A `clear` pulse sends the block back to pixel 0 of the current head word and drops any held packed bytes.
- R12: After reset with an empty FIFO, `pix_valid` and `fifo_rd` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart of position, phase and held bytes |
| cfg_size | input | 3 | Pixel width code (R1) |
| cfg_big_endian | input | 1 | 1: first pixel from the high end of the word |
| cfg_packed | input | 1 | 1: packed 24-bit layout |
| fifo_data | input | 32 | Head word of the FIFO |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rd | output | 1 | Pop the head word |
| pix_valid | output | 1 | A pixel is offered |
| pix_ready | input | 1 | Sink accepts the offered pixel |
| pix_data | output | 24 | Pixel value, zero-extended |

## Verification
The bench builds the block with its default parameters: 32-bit words and a 24-bit output. With these defaults every width code, both orders and both 24-bit layouts can be swept in full within a few hundred cycles each. The FIFO model releases words with gaps and the sink stalls in a fixed rhythm. This covers stalls on every pixel position, the empty-FIFO fourth packed pixel, and word pops in the middle of a stall. Separate runs pulse clear in the middle of a word and in the middle of a packed group.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
  localparam logic [2:0] SZ_CODE_24 = 3'd5;

  function automatic logic [2:0] clamp_size(input logic [2:0] code);
    return (code > SZ_CODE_24) ? SZ_CODE_24 : code;
  endfunction
endpackage

// File: rtl/pix_pos_counter.sv
module pix_pos_counter #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  assign wrap_o = (idx_o == last_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_o <= '0;
    else if (clear)  idx_o <= '0;
    else if (adv_i)  idx_o <= wrap_o ? '0 : idx_o + 1'b1;
  end

  // position never runs past the last pixel of a word
  assert_idx_in_word_R5: assert property (@(posedge clk) disable iff (!rst_n || clear)
    idx_o <= last_i);
endmodule

// File: rtl/pix_field_extract.sv
module pix_field_extract #(
  parameter int WORD_W  = 32,
  parameter int PIX_W   = 24,
  parameter int IDX_W   = 5,
  parameter int N_FIELD = 5
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [2:0]        size_i,
  input  logic              big_endian_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [N_FIELD-1:0][PIX_W-1:0] cand;

  for (genvar g = 0; g < N_FIELD; g++) begin : g_fld
    localparam int FW = 1 << g;
    logic [31:0]       amt;
    logic [WORD_W-1:0] sh;
    assign amt = big_endian_i
               ? 32'(WORD_W) - (32'(idx_i) + 32'd1) * 32'(FW)
               : 32'(idx_i) * 32'(FW);
    assign sh = word_i >> amt;
    assign cand[g] = PIX_W'(sh[FW-1:0]);
  end

  always_comb begin
    pix_o = '0;
    for (int i = 0; i < N_FIELD; i++)
      if (32'(size_i) == i) pix_o = cand[i];
  end
endmodule

// File: rtl/pix_pack24_unit.sv
module pix_pack24_unit #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fire_i,
  input  logic              big_endian_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        phase_o,
  output logic [PIX_W-1:0]  pix_o
);
  localparam int NB = WORD_W / 8;

  logic [7:0] s [NB];
  logic [7:0] c [3];
  logic [7:0] p0, p1, p2;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign s[i] = big_endian_i ? word_i[WORD_W-1-8*i -: 8] : word_i[8*i +: 8];
  end

  always_comb begin
    unique case (phase_o)
      2'd0:    begin p0 = s[0]; p1 = s[1]; p2 = s[2]; end
      2'd1:    begin p0 = c[0]; p1 = s[0]; p2 = s[1]; end
      2'd2:    begin p0 = c[0]; p1 = c[1]; p2 = s[0]; end
      default: begin p0 = c[0]; p1 = c[1]; p2 = c[2]; end
    endcase
    pix_o = big_endian_i ? PIX_W'({p0, p1, p2}) : PIX_W'({p2, p1, p0});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= 2'd0;
      c[0] <= '0; c[1] <= '0; c[2] <= '0;
    end else if (clear) begin
      phase_o <= 2'd0;
      c[0] <= '0; c[1] <= '0; c[2] <= '0;
    end else if (fire_i) begin
      phase_o <= phase_o + 2'd1;
      unique case (phase_o)
        2'd0:    c[0] <= s[3];
        2'd1:    begin c[0] <= s[2]; c[1] <= s[3]; end
        2'd2:    begin c[0] <= s[1]; c[1] <= s[2]; c[2] <= s[3]; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_pix_serializer.sv
module lcd_pix_serializer
  import pix_ser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [2:0]        cfg_size,
  input  logic              cfg_big_endian,
  input  logic              cfg_packed,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_rd,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [PIX_W-1:0]  pix_data
);
  localparam int IDX_W   = $clog2(WORD_W);
  localparam int N_FIELD = $clog2(WORD_W);

  logic [2:0]       size_c;
  logic             is24, packed24, fire, wrap;
  logic [IDX_W-1:0] last_idx, idx;
  logic [1:0]       phase;
  logic [PIX_W-1:0] fld_pix, pk_pix;

  assign size_c   = clamp_size(cfg_size);
  assign is24     = (size_c == SZ_CODE_24);
  assign packed24 = is24 && cfg_packed;
  assign last_idx = is24 ? '0 : IDX_W'((32'(WORD_W) >> size_c) - 32'd1);

  assign pix_valid = (packed24 && phase == 2'd3) || !fifo_empty;
  assign fire      = pix_valid && pix_ready;
  assign fifo_rd   = fire && (packed24 ? (phase != 2'd3) : (is24 || wrap));

  pix_pos_counter #(.IDX_W(IDX_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .adv_i(fire && !is24), .last_i(last_idx),
    .idx_o(idx), .wrap_o(wrap)
  );

  pix_field_extract #(.WORD_W(WORD_W), .PIX_W(PIX_W), .IDX_W(IDX_W), .N_FIELD(N_FIELD)) u_fld (
    .word_i(fifo_data), .size_i(size_c), .big_endian_i(cfg_big_endian),
    .idx_i(idx), .pix_o(fld_pix)
  );

  pix_pack24_unit #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_pk (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .fire_i(fire && packed24), .big_endian_i(cfg_big_endian),
    .word_i(fifo_data), .phase_o(phase), .pix_o(pk_pix)
  );

  always_comb begin
    if (packed24)  pix_data = pk_pix;
    else if (is24) pix_data = PIX_W'(fifo_data[23:0]);
    else           pix_data = fld_pix;
  end

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data)));

  assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !is24) |-> ((32'(pix_data) >> (32'd1 << size_c)) == 32'd0));

  // after the third word of a packed group is popped, held bytes give the next pixel
  assert_held_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (packed24 && fifo_rd && phase == 2'd2) |=> pix_valid);
endmodule

// File: tb/lcd_pix_serializer_bench.sv
module lcd_pix_serializer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic [2:0]  cfg_size = 3'd0;
  logic        cfg_big_endian = 1'b0;
  logic        cfg_packed = 1'b0;
  logic [31:0] fifo_data;
  logic        fifo_empty;
  logic        fifo_rd;
  logic        pix_valid;
  logic        pix_ready = 1'b0;
  logic [23:0] pix_data;

  logic [31:0] mem [16];
  int          rp = 0;
  int          avail = 0;
  logic        fifo_flush = 1'b0;
  int          tests = 0, fails = 0, cycles = 0;
  logic        timeout = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign fifo_data  = mem[rp % 16];
  assign fifo_empty = (rp >= avail);

  always @(posedge clk) begin
    if (fifo_flush)   rp <= 0;
    else if (fifo_rd) rp <= rp + 1;
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) timeout <= 1'b1;
  end

  lcd_pix_serializer u_lcd_pix_serializer (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .cfg_size(cfg_size), .cfg_big_endian(cfg_big_endian), .cfg_packed(cfg_packed),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_pix(input int k);
    logic [31:0] a, b, c, wd;
    int w, n, i, sh;
    if (cfg_size >= 3'd5 && !cfg_packed) return mem[k][23:0];
    if (cfg_size >= 3'd5) begin
      a = mem[3*(k/4)]; b = mem[3*(k/4)+1]; c = mem[3*(k/4)+2];
      case (k % 4)
        0: return cfg_big_endian ? a[31:8] : a[23:0];
        1: return cfg_big_endian ? {a[7:0], b[31:16]} : {b[15:0], a[31:24]};
        2: return cfg_big_endian ? {b[15:0], c[31:24]} : {c[7:0], b[31:16]};
        default: return cfg_big_endian ? c[23:0] : c[31:8];
      endcase
    end
    w = 1 << cfg_size; n = 32 / w;
    wd = mem[k / n]; i = k % n;
    sh = cfg_big_endian ? 32 - (i + 1) * w : i * w;
    return 24'((wd >> sh) & ((32'd1 << w) - 32'd1));
  endfunction

  function automatic string tag();
    if (cfg_size >= 3'd5) return cfg_packed ? (cfg_big_endian ? "R8" : "R7") : "R6 R1";
    return cfg_big_endian ? "R3 R1 R4" : "R2 R1 R4";
  endfunction

  task automatic start_stream(input logic [2:0] sz, input logic be, input logic pk, input int nw);
    @(negedge clk);
    cfg_size = sz; cfg_big_endian = be; cfg_packed = pk;
    fifo_flush = 1'b1; clear = 1'b1; avail = 0; pix_ready = 1'b0;
    for (int j = 0; j < 16; j++)
      mem[j] = (32'(j) * 32'h9E37_79B9) ^ {sz, be, pk, 27'h5A3_C96E} ^ (32'(j) << 29);
    @(negedge clk);
    fifo_flush = 1'b0; clear = 1'b0;
  endtask

  task automatic run_cfg(input logic [2:0] sz, input logic be, input logic pk,
                         input int nw, input bit always_ready);
    int npix, k, c;
    bit stalled;
    logic [23:0] held;
    logic exp_valid;
    start_stream(sz, be, pk, nw);
    if (sz >= 3'd5) npix = pk ? nw / 3 * 4 : nw;
    else npix = nw * (32 >> sz);
    k = 0; c = 0; stalled = 0; held = '0;
    while (k < npix && !timeout) begin
      @(negedge clk);
      c++;
      if ((c % 3) != 2 && avail < nw) avail++;
      pix_ready = always_ready ? 1'b1 : ((c % 4) != 1);
      #1;
      exp_valid = (sz >= 3'd5 && pk && (k % 4) == 3) || (rp < avail);
      check("R10 valid", 32'(pix_valid), 32'(exp_valid));
      if (stalled) begin
        check("R9 held valid", 32'(pix_valid), 32'd1);
        check("R9 held data", 32'(pix_data), 32'(held));
        stalled = 0;
      end
      if (pix_valid) begin
        if (pix_ready) begin
          check($sformatf("%s pixel %0d", tag(), k), 32'(pix_data), 32'(exp_pix(k)));
          k++;
        end else begin
          check("R9 no pop in stall", 32'(fifo_rd), 32'd0);
          stalled = 1; held = pix_data;
        end
      end
    end
    @(negedge clk);
    pix_ready = 1'b0;
    #1;
    check("R5 words popped", 32'(rp), 32'(nw));
    check("R5 nothing left offered", 32'(pix_valid), 32'd0);
  endtask

  task automatic clear_test(input logic [2:0] sz, input logic pk);
    int got;
    start_stream(sz, 1'b0, pk, 6);
    avail = 6;
    got = 0;
    while (got < 2 && !timeout) begin
      @(negedge clk);
      pix_ready = 1'b1;
      #1;
      if (pix_valid) got++;
    end
    @(negedge clk);
    pix_ready = 1'b0; clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    #1;
    check("R11 valid after clear", 32'(pix_valid), 32'd1);
    if (pk) check("R11 packed restart", 32'(pix_data), 32'(mem[rp][23:0]));
    else    check("R11 word restart", 32'(pix_data), 32'(mem[rp][7:0]));
  endtask

  initial begin
    for (int j = 0; j < 16; j++) mem[j] = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R12 reset valid", 32'(pix_valid), 32'd0);
    check("R12 reset pop", 32'(fifo_rd), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R12 after reset valid", 32'(pix_valid), 32'd0);
    for (int s = 0; s < 5; s++)
      for (int e = 0; e < 2; e++)
        run_cfg(3'(s), e[0], 1'b0, 4, 1'b0);
    for (int e = 0; e < 2; e++) begin
      run_cfg(3'd5, e[0], 1'b0, 6, 1'b0);
      run_cfg(3'd5, e[0], 1'b1, 12, 1'b0);
      run_cfg(3'd5, e[0], 1'b1, 6, 1'b1);
    end
    run_cfg(3'd7, 1'b0, 1'b0, 5, 1'b1);
    run_cfg(3'd6, 1'b1, 1'b1, 9, 1'b0);
    run_cfg(3'd3, 1'b1, 1'b0, 3, 1'b1);
    clear_test(3'd3, 1'b0);
    clear_test(3'd5, 1'b1);
    if (!timeout) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait (timeout);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule